// File: doc/BRIEF.md
# Receive Byte Buffer with Prioritised Interrupt Identification

This block holds bytes that arrive from a serial receive channel until a host collects them through a small register window. Each byte offered on the receive strobe is appended to a 64-deep first-in, first-out store. Each host read of the data address removes the oldest byte. The host can read how many bytes are waiting. It can choose a fill threshold and can empty the store with one control write.

Three interrupt sources share one active-low request line. The first is a fill threshold reached. The second is an idle timeout: bytes are waiting but neither a new arrival nor a host read has happened for a set number of cycles. The third is a transmit-room event, signalled by a pulse from the neighbouring transmit side. A read of the identification register returns a fixed code for the highest-priority pending source. The lowest bit of that code is zero while something is pending. The read also clears the two event-style sources.

Top module: `rx_intr_buffer`

## Requirements
- R1: The fill level (0 to 64) reads back at register address 0x9, with bit 7 always 0. Each accepted byte raises it by one and each pop lowers it by one.
- R2: Reads at address 0x0 return the stored bytes in arrival order, and each such read removes one byte.
- R3: A read at address 0x0 while the store is empty returns 0x00 and leaves the level at 0.
- R4: A byte offered while 64 bytes are stored and no pop happens in the same cycle is discarded, and the stored contents stay the same.
- R5: A byte arrival and a pop in the same cycle leave the level unchanged and keep the arrival order.
- R6: Writing address 0x2 loads the threshold from bits 7:6 (00 = 8, 01 = 16, 10 = 32, 11 = 64; 11 after reset). The threshold source is pending exactly while the level is at or above the threshold.
- R7: While the store holds data, the timeout source becomes pending TIMEOUT cycles after the last accepted byte, pop or clear. It never becomes pending while the store is empty, and it stays pending until an identification read.
- R8: Reading address 0x2 returns 0x0C for timeout, 0x04 for threshold, 0x02 for transmit room and 0x01 for none, with priority in that order. Bits 7:6 are always 0.
- R9: An identification read clears the timeout and transmit-room sources. A source raised in the same cycle as the read stays pending.
- R10: A one-cycle pulse on `tx_room_evt` makes the transmit-room source pending.
- R11: Writing address 0x2 with bit 1 set empties the store and cancels a pending timeout.
- R12: `irq_n` is low exactly while at least one source is pending.
- R13: After reset, the level is 0, the threshold is 64, no source is pending and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_data | input | 8 | The received byte |
| tx_room_evt | input | 1 | Pulse raising the transmit-room source |
| reg_rd | input | 1 | Host register read strobe |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from the address |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Two pairs of events can land in the same cycle. The first pair is a byte arrival and a host pop. The bench provokes it both with directed steps and with random phases that drive arrivals and data reads at random in the same cycles. It judges the result from the popped values and from later level reads, compared against a queue model that applies the pop before deciding whether the arrival fits. The second pair is an identification read and the arrival of a transmit-room pulse. This case is driven directly, and it passes only if the source is still pending on the next read.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam logic [3:0] ADDR_DATA = 4'h0;
    localparam logic [3:0] ADDR_CTRL = 4'h2;
    localparam logic [3:0] ADDR_LVL  = 4'h9;

    localparam logic [7:0] ID_TIMEOUT = 8'h0C;
    localparam logic [7:0] ID_THRESH  = 8'h04;
    localparam logic [7:0] ID_TXROOM  = 8'h02;
    localparam logic [7:0] ID_NONE    = 8'h01;

    typedef struct packed {
        logic [1:0] trig;
        logic       to_pend;
        logic       thr_pend;
    } ctl_t;

    function automatic int unsigned thresh_of(input logic [1:0] code, input int unsigned depth);
        case (code)
            2'b00:   return depth / 8;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth;
        endcase
    endfunction
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             clear,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fst_t;

    fst_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign empty = (s_q.cnt == '0);
    assign full  = (32'(s_q.cnt) == DEPTH);
    assign count = s_q.cnt;
    assign head  = empty ? '0 : mem_q[s_q.rd];

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && !empty && !clear;
        do_push = push && (!full || do_pop) && !clear;
        if (clear) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wr = bump(s_q.wr);
            if (do_pop)  s_d.rd = bump(s_q.rd);
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wr] <= din;
    end
endmodule

// File: rtl/rxb_idle_timer.sv
module rxb_idle_timer #(
    parameter int unsigned TIMEOUT = 64,
    localparam int unsigned TW = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic restart,
    output logic expire
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (restart || !armed) begin
            cnt_d = '0;
        end else if (32'(cnt_q) < TIMEOUT) begin
            cnt_d = cnt_q + 1'b1;
            if (32'(cnt_q) == TIMEOUT - 1) expire = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rxb_irq_encode.sv
module rxb_irq_encode (
    input  logic       to_src,
    input  logic       thresh_src,
    input  logic       txroom_src,
    output logic [7:0] ident,
    output logic       any
);
    import rxb_pkg::*;

    always_comb begin
        if (to_src)          ident = ID_TIMEOUT;
        else if (thresh_src) ident = ID_THRESH;
        else if (txroom_src) ident = ID_TXROOM;
        else                 ident = ID_NONE;
        any = to_src || thresh_src || txroom_src;
    end
endmodule

// File: rtl/rx_intr_buffer.sv
module rx_intr_buffer #(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned TIMEOUT = 64,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_room_evt,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_n
);
    import rxb_pkg::*;

    ctl_t c_d, c_q;

    logic             data_rd, ident_rd, ctrl_wr, clr;
    logic [7:0]       head;
    logic [CNT_W-1:0] fifo_count;
    logic             f_empty, f_full, accept, popping;
    logic             expire, thresh_src, any_src;
    logic [7:0]       ident;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[5:2], reg_wdata[0]};

    assign data_rd  = reg_rd && (reg_addr == ADDR_DATA);
    assign ident_rd = reg_rd && (reg_addr == ADDR_CTRL);
    assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
    assign clr      = ctrl_wr && reg_wdata[1];
    assign popping  = data_rd && !f_empty && !clr;
    assign accept   = rx_valid && (!f_full || popping) && !clr;

    rxb_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid),
        .din   (rx_data),
        .pop   (data_rd),
        .clear (clr),
        .head  (head),
        .count (fifo_count),
        .empty (f_empty),
        .full  (f_full)
    );

    rxb_idle_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (!f_empty),
        .restart (accept || popping || clr),
        .expire  (expire)
    );

    assign thresh_src = 32'(fifo_count) >= thresh_of(c_q.trig, DEPTH);

    rxb_irq_encode u_enc (
        .to_src     (c_q.to_pend),
        .thresh_src (thresh_src),
        .txroom_src (c_q.thr_pend),
        .ident      (ident),
        .any        (any_src)
    );

    always_comb begin
        c_d = c_q;
        if (ctrl_wr) c_d.trig = reg_wdata[7:6];
        if (ident_rd) begin
            c_d.to_pend  = 1'b0;
            c_d.thr_pend = 1'b0;
        end
        if (expire)      c_d.to_pend  = 1'b1;
        if (clr)         c_d.to_pend  = 1'b0;
        if (tx_room_evt) c_d.thr_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{trig: 2'b11, to_pend: 1'b0, thr_pend: 1'b0};
        else        c_q <= c_d;
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_rd) begin
            case (reg_addr)
                ADDR_DATA: reg_rdata = head;
                ADDR_CTRL: reg_rdata = ident;
                ADDR_LVL:  reg_rdata = 8'(fifo_count);
                default:   reg_rdata = 8'h00;
            endcase
        end
    end

    assign irq_n = !any_src;
endmodule

// File: rtl/rx_intr_buffer_chk.sv
module rx_intr_buffer_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic [7:0]    reg_wdata,
    input logic [7:0]    reg_rdata,
    input logic          irq_n,
    input logic [CW-1:0] level
);
    import rxb_pkg::*;

    logic drd, crd, cwr;
    assign drd = reg_rd && reg_addr == ADDR_DATA;
    assign crd = reg_rd && reg_addr == ADDR_CTRL;
    assign cwr = reg_wr && reg_addr == ADDR_CTRL;

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(level) <= DEPTH);
    p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drd && level == 0 |-> reg_rdata == 8'h00);
    p_empty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drd && level == 0 && !rx_valid && !reg_wr |=> level == 0);
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(level) == DEPTH && rx_valid && !drd && !reg_wr |=> 32'(level) == DEPTH);
    p_push_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && drd && level != 0 && !reg_wr |=> $stable(level));
    p_full_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(level) == DEPTH |-> !irq_n);
    p_ident_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        crd |-> reg_rdata[7:6] == 2'b00);
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cwr && reg_wdata[1] |=> level == 0);
    p_irq_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
        crd |-> irq_n == reg_rdata[0]);
endmodule

bind rx_intr_buffer rx_intr_buffer_chk #(.DEPTH(DEPTH), .CW(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n),
    .level     (fifo_count)
);

// File: tb/rx_intr_buffer_bench.sv
module rx_intr_buffer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int TMO   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, tx_room_evt = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] rx_data = 8'h00, reg_wdata = 8'h00;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_rdata;
    logic irq_n;

    int total = 0;
    int bad = 0;
    logic [7:0] model_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_intr_buffer #(.DEPTH(DEPTH), .TIMEOUT(TMO)) u_rx_intr_buffer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_room_evt(tx_room_evt), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n)
    );

    function automatic logic [7:0] ident_exp(input bit to, input bit th, input bit tr);
        if (to) return 8'h0C;
        if (th) return 8'h04;
        if (tr) return 8'h02;
        return 8'h01;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic rv, input logic [7:0] rb, input logic rd,
                        input logic wr, input logic [3:0] a, input logic [7:0] wd,
                        input logic te);
        @(negedge clk);
        rx_valid = rv; rx_data = rb; reg_rd = rd; reg_wr = wr;
        reg_addr = a; reg_wdata = wd; tx_room_evt = te;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 4'h0, 8'h00, 0);
    endtask

    task automatic push(input logic [7:0] b);
        step(1, b, 0, 0, 4'h0, 8'h00, 0);
    endtask

    task automatic rreg(input logic [3:0] a, output logic [7:0] d);
        step(0, 8'h00, 1, 0, a, 8'h00, 0);
        d = reg_rdata;
    endtask

    task automatic wctl(input logic [7:0] v);
        step(0, 8'h00, 0, 1, 4'h2, v, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int lvl;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R13 reset state
        chk("R13 irq_n", irq_n, 1);
        rreg(4'h9, d); chk("R13 level", d, 0);
        rreg(4'h2, d); chk("R13 ident", d, ident_exp(0, 0, 0));

        // R3 empty read
        rreg(4'h0, d); chk("R3 empty data", d, 0);
        rreg(4'h9, d); chk("R3 empty level", d, 0);

        // R7 timeout fires exactly TMO cycles after last byte
        push(8'hA5);
        idle(TMO);
        chk("R7 not yet", irq_n, 1);
        idle(1);
        chk("R7 fired irq", irq_n, 0);
        rreg(4'h2, d); chk("R8 timeout code", d, 8'h0C);
        idle(1);
        chk("R9 cleared by ident read", irq_n, 1);
        rreg(4'h0, d); chk("R2 pop value", d, 8'hA5);
        idle(3 * TMO);
        chk("R7 never when empty", irq_n, 1);

        // R7 restart on pop
        push(8'h11); push(8'h22);
        idle(10);
        rreg(4'h0, d); chk("R2 first", d, 8'h11);
        idle(TMO);
        chk("R7 restart by read", irq_n, 1);
        idle(1);
        chk("R7 fired after read", irq_n, 0);
        // R11 clear cancels timeout, keeps code 11
        wctl(8'hC2);
        idle(1);
        chk("R11 irq cleared", irq_n, 1);
        rreg(4'h9, d); chk("R11 level zero", d, 0);

        // R6 threshold code 00 = 8
        wctl(8'h00);
        for (int i = 0; i < 7; i++) push(8'(i));
        idle(1);
        chk("R6 below threshold", irq_n, 1);
        push(8'h07);
        idle(1);
        chk("R6 at threshold irq", irq_n, 0);
        rreg(4'h2, d); chk("R6 thresh code", d, 8'h04);
        rreg(4'h0, d); chk("R2 order", d, 8'h00);
        rreg(4'h2, d); chk("R6 below after pop", d, 8'h01);

        // R8 priority with all sources, R10 tx room
        push(8'h08);
        idle(TMO + 4);
        step(0, 8'h00, 0, 0, 4'h0, 8'h00, 1);
        rreg(4'h2, d); chk("R8 timeout over others", d, 8'h0C);
        rreg(4'h2, d); chk("R9 thresh remains", d, 8'h04);
        step(0, 8'h00, 0, 0, 4'h0, 8'h00, 1);
        wctl(8'h02);
        rreg(4'h2, d); chk("R10 tx room code", d, 8'h02);
        rreg(4'h2, d); chk("R9 tx room cleared", d, 8'h01);

        // R9 ident read in same cycle as tx room pulse
        step(0, 8'h00, 1, 0, 4'h2, 8'h00, 1);
        idle(1);
        chk("R9 same cycle irq", irq_n, 0);
        rreg(4'h2, d); chk("R9 same cycle survives", d, 8'h02);
        idle(1);
        chk("R12 none pending", irq_n, 1);

        // R4 full and drop, code 11
        wctl(8'hC0);
        for (int i = 0; i < DEPTH; i++) push(8'(i + 8'h40));
        push(8'hEE);
        idle(1);
        rreg(4'h9, d); chk("R4 level stays full", d, DEPTH);
        chk("R12 irq at full", irq_n, 0);
        rreg(4'h2, d); chk("R6 full code", d, 8'h04);
        for (int i = 0; i < DEPTH; i++) begin
            rreg(4'h0, d); chk("R4 drained order", d, i + 8'h40);
        end
        rreg(4'h0, d); chk("R4 extra byte dropped", d, 0);
        rreg(4'h9, d); chk("R1 drained", d, 0);

        // R5 push and pop same cycle
        push(8'h31); push(8'h32); push(8'h33);
        step(1, 8'h34, 1, 0, 4'h0, 8'h00, 0);
        d = reg_rdata; chk("R5 popped oldest", d, 8'h31);
        rreg(4'h9, d); chk("R5 level same", d, 3);
        for (int i = 0; i < 3; i++) begin
            rreg(4'h0, d); chk("R5 order kept", d, 8'h32 + i);
        end

        // random phase: R1 R2 R4 R5 against queue model
        model_q.delete();
        void'($urandom(32'h5EED));
        for (int n = 0; n < 3000; n++) begin
            logic rv, rd;
            logic [7:0] b;
            bit popped;
            rv = ($urandom % 100) < 55;
            rd = ($urandom % 100) < 45;
            b  = 8'($urandom);
            if (n % 97 == 96) begin
                rreg(4'h9, d); chk("R1 random level", d, model_q.size());
            end else begin
                step(rv, b, rd, 0, 4'h0, 8'h00, 0);
                popped = 0;
                if (rd) begin
                    d = reg_rdata;
                    chk("R2 random pop", d, model_q.size() != 0 ? model_q[0] : 0);
                    if (model_q.size() != 0) begin
                        void'(model_q.pop_front());
                        popped = 1;
                    end
                end
                if (rv && (model_q.size() < DEPTH || popped)) model_q.push_back(b);
            end
        end
        lvl = model_q.size();
        rreg(4'h9, d); chk("R1 final level", d, lvl);
        wctl(8'hC2);
        rreg(4'h9, d); chk("R11 final clear", d, 0);
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule